// File: doc/BRIEF.md
# SMBus Target Transaction Sequencer

This block sits on top of a byte-level I2C target engine and turns its event strobes into SMBus-style transactions for a user-side register model. The byte engine reports a start for a write, a start for a read, a stop, and a NACK from the controller. It also delivers each received byte and asks for each byte the controller reads. The bit-level SCL/SDA layer, address matching and packet error checking belong to other blocks.

Written bytes collect in a buffer of `DEPTH` entries, and byte 0 is the command code. When a transaction ends, the sequencer raises a one-cycle pulse. A zero-length transaction becomes a quick command that carries its direction. A write becomes a block write that exposes the buffer and its length. If a repeated start turns a write into a read, the buffered write is handed over at that point, and each byte the controller then reads is fetched through a one-cycle read request. Protocol mistakes send the sequencer into an error state and raise sticky error flags. Only a stop clears either of them.

Top module: `smbus_txn_seq`

## Requirements
- R1: With `rst` high at a clock edge, the block returns to idle with zero buffered bytes. All pulses are low, `err_flags` is 0 and `tx_byte` is 0xFF.
- R2: Start-for-write, then N bytes with 1 <= N <= DEPTH, then stop: in the cycle after the stop, `wr_valid` is high for exactly one cycle. In that cycle `wr_len`=N, `wr_cmd` holds the first byte, and byte i sits at `wr_buf[8*i +: 8]`.
- R3: A start followed directly by a stop, with no bytes buffered, gives a one-cycle `quick_valid` in the cycle after the stop. `quick_dir` is 0 if the transaction began as a write and 1 if it began as a read. No `wr_valid` is raised.
- R4: When a start-for-read arrives during a write that has at least one buffered byte, `wr_valid` is raised in the next cycle with the buffered length, and the block enters the read phase.
- R5: In the read phase, a read request `tx_req` raises `rd_req` in the same cycle. In the next cycle `tx_byte` holds `usr_rd_data` if `usr_rd_ok` is high, and 0xFF if it is low.
- R6: A NACK in the read phase leads to the done state. A further NACK there is ignored and leaves `err_flags` at 0. A stop from the done state raises no pulse and no error.
- R7: `err_flags[0]` (protocol error) is set in the next cycle by any of these: a start-for-write outside idle, a start-for-read that is neither in idle nor in a write with bytes buffered, or a NACK outside the read and done states. While in this error state, a stop issues no request.
- R8: A `tx_req` outside the read phase leaves `rd_req` low, sets `tx_byte` to 0xFF and sets `err_flags[0]`.
- R9: During a write, bytes after the DEPTH-th are dropped and set `err_flags[1]`, and the length stays at DEPTH.
- R10: A byte received outside the write phase is dropped and sets `err_flags[2]`. It does not appear in a later write.
- R11: A stop in the read phase with bytes still buffered sets `err_flags[3]` and raises no request. Any other stop clears `err_flags`. Every stop returns the block to idle with zero length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_start_wr | input | 1 | Start (or repeated start) addressed for write |
| ev_start_rd | input | 1 | Start (or repeated start) addressed for read |
| ev_stop | input | 1 | Stop / end of transaction |
| ev_nack | input | 1 | Controller NACKed a read byte |
| rx_valid | input | 1 | A received byte is present |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Controller reads one byte |
| usr_rd_data | input | 8 | User read data |
| usr_rd_ok | input | 1 | User read data is available |
| rd_req | output | 1 | Read request to user (same cycle as tx_req) |
| tx_byte | output | 8 | Byte returned to the controller |
| quick_valid | output | 1 | Quick command pulse |
| quick_dir | output | 1 | Quick command direction, 1 = read |
| wr_valid | output | 1 | Block write pulse |
| wr_len | output | $clog2(DEPTH+1) | Block write length |
| wr_cmd | output | 8 | Command code (buffer byte 0) |
| wr_buf | output | 8*DEPTH | Flattened buffer, byte i at bits 8*i+7:8*i |
| err_flags | output | 4 | Sticky flags: protocol, overflow, stray byte, stop in read |

## Verification
The bench targets the repeated-start flush. A design that waits for the stop to flush would raise no write pulse before the read bytes, and one that clears the length at the flush would miss the stop-in-read error. It also tests the quick-command direction for both kinds of start, where a swapped direction bit or a block write of zero length would show at once. Overflow is driven at a small depth to catch a length that wraps or a last byte that is overwritten. Stray bytes, misplaced NACKs and reads outside the read phase are each followed by a stop and a clean transaction. A flag that never clears or an error state that leaks into the next transaction would fail there.

// File: rtl/smbus_txn_seq.sv
module smbus_txn_seq #(
  parameter int DEPTH = 32,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ev_start_wr,
  input  logic               ev_start_rd,
  input  logic               ev_stop,
  input  logic               ev_nack,
  input  logic               rx_valid,
  input  logic [7:0]         rx_byte,
  input  logic               tx_req,
  input  logic [7:0]         usr_rd_data,
  input  logic               usr_rd_ok,
  output logic               rd_req,
  output logic [7:0]         tx_byte,
  output logic               quick_valid,
  output logic               quick_dir,
  output logic               wr_valid,
  output logic [LW-1:0]      wr_len,
  output logic [7:0]         wr_cmd,
  output logic [8*DEPTH-1:0] wr_buf,
  output logic [3:0]         err_flags
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [LW-1:0] FULL = LW'(DEPTH);

  typedef enum logic [2:0] {S_IDLE, S_WR, S_RD, S_DONE, S_BAD} st_t;
  st_t           st;
  logic [LW-1:0] len;
  logic [7:0]    buf_q [DEPTH];

  logic ctl_ev, rx_take;
  assign ctl_ev  = ev_stop | ev_nack | ev_start_wr | ev_start_rd;
  assign rx_take = !ctl_ev && rx_valid && st == S_WR && len < FULL;
  assign rd_req  = !ctl_ev && !rx_valid && tx_req && st == S_RD;
  assign wr_cmd  = buf_q[0];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_flat
    assign wr_buf[8*gi +: 8] = buf_q[gi];
  end

  always_ff @(posedge clk) begin
    if (rx_take) buf_q[len[AW-1:0]] <= rx_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_IDLE;
      len         <= '0;
      quick_valid <= 1'b0;
      quick_dir   <= 1'b0;
      wr_valid    <= 1'b0;
      wr_len      <= '0;
      err_flags   <= '0;
      tx_byte     <= 8'hFF;
    end else begin
      quick_valid <= 1'b0;
      wr_valid    <= 1'b0;
      if (ev_stop) begin
        err_flags <= '0;
        if (len == '0) begin
          if (st == S_WR || st == S_RD) begin
            quick_valid <= 1'b1;
            quick_dir   <= (st == S_RD);
          end
        end else if (st == S_WR) begin
          wr_valid <= 1'b1;
          wr_len   <= len;
        end else if (st == S_RD) begin
          err_flags <= 4'b1000;
        end
        st  <= S_IDLE;
        len <= '0;
      end else if (ev_nack) begin
        if (st == S_RD) st <= S_DONE;
        else if (st != S_DONE) begin
          st <= S_BAD;
          err_flags[0] <= 1'b1;
        end
      end else if (ev_start_wr) begin
        if (st == S_IDLE) st <= S_WR;
        else begin
          st <= S_BAD;
          err_flags[0] <= 1'b1;
        end
      end else if (ev_start_rd) begin
        if (st == S_IDLE) st <= S_RD;
        else if (st == S_WR && len != '0) begin
          wr_valid <= 1'b1;
          wr_len   <= len;
          st       <= S_RD;
        end else begin
          st <= S_BAD;
          err_flags[0] <= 1'b1;
        end
      end else if (rx_valid) begin
        if (st == S_WR) begin
          if (len < FULL) len <= len + LW'(1);
          else err_flags[1] <= 1'b1;
        end else err_flags[2] <= 1'b1;
      end else if (tx_req) begin
        if (st == S_RD) tx_byte <= usr_rd_ok ? usr_rd_data : 8'hFF;
        else begin
          tx_byte <= 8'hFF;
          st <= S_BAD;
          err_flags[0] <= 1'b1;
        end
      end
    end
  end

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
    ev_stop |=> (st == S_IDLE && len == '0)); // R11
  AST_QUICK_READ: assert property (@(posedge clk) disable iff (rst)
    (ev_stop && st == S_RD && len == '0) |=> (quick_valid && quick_dir && !wr_valid)); // R3
  AST_FLUSH_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (!ev_stop && !ev_nack && !ev_start_wr && ev_start_rd && st == S_WR && len != '0)
      |=> (wr_valid && st == S_RD)); // R4
  AST_NACK_DONE: assert property (@(posedge clk) disable iff (rst)
    (!ev_stop && ev_nack && (st == S_RD || st == S_DONE)) |=> st == S_DONE); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    len <= FULL); // R9
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (!ctl_ev && rx_valid && st == S_WR && len == FULL) |=> (err_flags[1] && len == FULL)); // R9
  AST_TX_IDLE_FF: assert property (@(posedge clk) disable iff (rst)
    (!ctl_ev && !rx_valid && tx_req && st != S_RD) |=> (tx_byte == 8'hFF && err_flags[0])); // R8
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    !(quick_valid && wr_valid)); // R2
endmodule

// File: tb/smbus_txn_seq_tb_top.sv
module smbus_txn_seq_tb_top;
  localparam int DEPTH = 4;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic ev_start_wr = 0, ev_start_rd = 0, ev_stop = 0, ev_nack = 0;
  logic rx_valid = 0, tx_req = 0, usr_rd_ok = 0;
  logic [7:0] rx_byte = 0, usr_rd_data = 0;
  logic rd_req, quick_valid, quick_dir, wr_valid;
  logic [7:0] tx_byte, wr_cmd;
  logic [LW-1:0] wr_len;
  logic [8*DEPTH-1:0] wr_buf;
  logic [3:0] err_flags;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  smbus_txn_seq #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .ev_start_wr(ev_start_wr), .ev_start_rd(ev_start_rd),
    .ev_stop(ev_stop), .ev_nack(ev_nack), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_req(tx_req), .usr_rd_data(usr_rd_data), .usr_rd_ok(usr_rd_ok),
    .rd_req(rd_req), .tx_byte(tx_byte), .quick_valid(quick_valid),
    .quick_dir(quick_dir), .wr_valid(wr_valid), .wr_len(wr_len), .wr_cmd(wr_cmd),
    .wr_buf(wr_buf), .err_flags(err_flags));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  // 0 start_wr, 1 start_rd, 2 stop, 3 nack
  task automatic ev(input int k);
    ev_start_wr = (k == 0); ev_start_rd = (k == 1);
    ev_stop = (k == 2); ev_nack = (k == 3);
    @(negedge clk);
    ev_start_wr = 0; ev_start_rd = 0; ev_stop = 0; ev_nack = 0;
  endtask

  task automatic send(input logic [7:0] b);
    rx_valid = 1; rx_byte = b;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic rd(input logic [7:0] d, input bit ok, input bit exp_req);
    tx_req = 1; usr_rd_data = d; usr_rd_ok = ok;
    #1 eq("R5 rd_req", int'(rd_req), int'(exp_req));
    @(negedge clk);
    tx_req = 0; usr_rd_ok = 0;
  endtask

  task automatic t_reset;
    eq("R1 err", err_flags, 0);
    eq("R1 tx_byte", tx_byte, 8'hFF);
    eq("R1 pulses", {quick_valid, wr_valid, rd_req}, 0);
  endtask

  task automatic t_write;
    ev(0); send(8'hA5); send(8'h11); send(8'h22); ev(2);
    eq("R2 wr_valid", wr_valid, 1);
    eq("R2 wr_len", wr_len, 3);
    eq("R2 wr_cmd", wr_cmd, 8'hA5);
    eq("R2 byte1", wr_buf[15:8], 8'h11);
    eq("R2 byte2", wr_buf[23:16], 8'h22);
    eq("R2 no quick", quick_valid, 0);
    @(negedge clk);
    eq("R2 one cycle", wr_valid, 0);
  endtask

  task automatic t_quick;
    ev(0); ev(2);
    eq("R3 quick wr", quick_valid, 1);
    eq("R3 dir wr", quick_dir, 0);
    eq("R3 no wr", wr_valid, 0);
    ev(1); ev(2);
    eq("R3 quick rd", quick_valid, 1);
    eq("R3 dir rd", quick_dir, 1);
    @(negedge clk);
    eq("R3 one cycle", quick_valid, 0);
  endtask

  task automatic t_rep_start;
    ev(0); send(8'h07); ev(1);
    eq("R4 flush", wr_valid, 1);
    eq("R4 len", wr_len, 1);
    eq("R4 cmd", wr_cmd, 8'h07);
    rd(8'h3C, 1, 1);
    eq("R5 data", tx_byte, 8'h3C);
    rd(8'h00, 0, 1);
    eq("R5 no data", tx_byte, 8'hFF);
    ev(3); ev(3);
    eq("R6 nack err", err_flags, 0);
    ev(2);
    eq("R6 stop done", {quick_valid, wr_valid, err_flags}, 0);
  endtask

  task automatic t_stop_in_read;
    ev(0); send(8'h09); ev(1); rd(8'h41, 1, 1); ev(2);
    eq("R11 stop in read", err_flags, 4'b1000);
    eq("R11 no req", {quick_valid, wr_valid}, 0);
    ev(0); ev(2);
    eq("R11 cleared", err_flags, 0);
    eq("R11 idle after", quick_valid, 1);
  endtask

  task automatic t_bad_events;
    ev(0); ev(0);
    eq("R7 double start", err_flags[0], 1);
    ev(2);
    eq("R7 stop clears", err_flags, 0);
    ev(0); ev(1);
    eq("R7 empty rd", err_flags[0], 1);
    eq("R7 no flush", wr_valid, 0);
    ev(2);
    eq("R7 no quick", quick_valid, 0);
    ev(3);
    eq("R7 idle nack", err_flags[0], 1);
    ev(2);
    rd(8'h55, 1, 0);
    eq("R8 tx ff", tx_byte, 8'hFF);
    eq("R8 err", err_flags[0], 1);
    ev(2);
  endtask

  task automatic t_overflow;
    ev(0);
    for (int i = 1; i <= DEPTH; i++) send(8'(i));
    eq("R9 no err at full", err_flags[1], 0);
    send(8'hEE); send(8'hEF);
    eq("R9 overflow", err_flags[1], 1);
    ev(2);
    eq("R9 len", wr_len, DEPTH);
    eq("R9 last byte", wr_buf[8*DEPTH-1 -: 8], DEPTH);
    eq("R9 first byte", wr_cmd, 1);
  endtask

  task automatic t_stray;
    send(8'h77);
    eq("R10 stray", err_flags[2], 1);
    ev(2);
    ev(0); send(8'h88); ev(2);
    eq("R10 len", wr_len, 1);
    eq("R10 cmd", wr_cmd, 8'h88);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_write();
    t_quick();
    t_rep_start();
    t_stop_in_read();
    t_bad_events();
    t_overflow();
    t_stray();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule